// File: doc/BRIEF.md
# Multi-Mode Interval Counter Channel

This block is one programmable interval counter channel. A 16-bit reload value and a 3-bit mode code are captured together on a load strobe. The channel then counts pulses of a counting-clock enable and drives one output line with one of six waveforms: a one-shot that latches high, a gate-retriggered one-shot, a rate generator, a square wave, and two single-tick strobes, one started by software and one by hardware. A reload of zero stands for a terminal count of 65536.

The live count value is always available for readback. A gate input can retrigger a period or hold the count, depending on the mode. The channel is meant to be instantiated once per timer in a larger timer complex. That complex provides the host access, the counting-clock enable and the routing of the output line.

Top module: `interval_counter`

## Requirements
- R1: After reset the channel runs a square wave with terminal count 65536. `count_val` reads 0 and `out_line` is high. `out_line` stays high for the first 32768 ticks and falls on tick 32768, when `count_val` again reads 0.
- R2: On the cycle after a load strobe, `count_val` equals `reload_val` in every mode. A `reload_val` of 0 gives a terminal count of 65536, so counting down one tick from it reads 0xFFFF.
- R3: In mode code 0, `out_line` is low after a load and goes high on the tick that brings the elapsed count to the terminal count. It then stays high until the next load. While `gate` is low, ticks are ignored.
- R4: In mode code 1, `out_line` is low for the first N ticks and then high. A rising edge on `gate` restarts the period: `count_val` returns to N and `out_line` goes low.
- R5: In mode code 2, `out_line` is high for exactly one tick interval each time the elapsed ticks reach a non-zero multiple of N. The period then repeats with no reload. `count_val` reads N minus the position within the period.
- R6: In mode code 3, `out_line` is high for the first (N+1)/2 ticks of each period and low for the rest. `count_val` reads N minus (2 x position mod N), so it falls by two per tick within each half.
- R7: In mode code 4, `out_line` is high for exactly one tick interval once the elapsed ticks equal N. It does not repeat. While `gate` is low, ticks are ignored.
- R8: In mode code 5, `out_line` behaves as in mode 4, and a rising edge on `gate` restarts the count from N.
- R9: In mode codes 0 and 4, a rising edge on `gate` does not restart the count.
- R10: In mode codes 0, 1, 4 and 5, `count_val` is N minus the elapsed ticks modulo 65536, so it wraps from 0 to 0xFFFF and keeps falling.
- R11: Without a `tick`, a load or a retriggering gate edge, neither `count_val` nor `out_line` changes.
- R12: Mode code 6 behaves as mode 2, and mode code 7 behaves as mode 3.
- R13: `mode_sel` is sampled only on a load strobe. Changing it at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counting-clock enable; one tick per asserted cycle |
| gate | input | 1 | Gate level: hold in modes 0/4, retrigger on rising edge in modes 1/2/3/5 |
| load | input | 1 | Load strobe capturing `reload_val` and `mode_sel` |
| reload_val | input | 16 | Reload value, 0 meaning 65536 |
| mode_sel | input | 3 | Counting mode code |
| out_line | output | 1 | Channel output waveform |
| count_val | output | 16 | Live count value for readback |

## Verification
On every cycle, the assertions check four things. The count equals the reload value right after a load. Nothing moves without a tick, load or retriggering edge. A held gate freezes mode 0. The latched mode-0 output and the one-tick mode-4 strobe behave as specified. Only the bench scenarios can show the waveforms themselves: where the pulses of the rate and square-wave modes fall, the odd-count half periods, gate retriggering in modes 1 and 5, the count wrapping past zero, the folding of codes 6 and 7, and the long reset period of 65536.

// File: rtl/ictr_pkg.sv
package ictr_pkg;
    localparam int CNT_W  = 16;
    localparam int TERM_W = CNT_W + 1;

    typedef enum logic [2:0] {
        M_ONESHOT  = 3'd0,
        M_RETRIG   = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } op_mode_e;

    typedef struct packed {
        op_mode_e            mode;
        logic [TERM_W-1:0]   term;
    } chan_cfg_t;

    // zero reload stands for the full 2**CNT_W period
    function automatic logic [TERM_W-1:0] expand_reload(input logic [CNT_W-1:0] v);
        if (v == '0)
            return TERM_W'(1) << CNT_W;
        return {1'b0, v};
    endfunction

    function automatic op_mode_e fold_mode(input logic [2:0] m);
        case (m)
            3'd0:    return M_ONESHOT;
            3'd1:    return M_RETRIG;
            3'd2:    return M_RATE;
            3'd4:    return M_SWSTROBE;
            3'd5:    return M_HWSTROBE;
            3'd6:    return M_RATE;
            default: return M_SQUARE;
        endcase
    endfunction

    function automatic logic is_gated(input op_mode_e m);
        return (m == M_ONESHOT) || (m == M_SWSTROBE);
    endfunction

    function automatic logic is_retrig(input op_mode_e m);
        return (m == M_RETRIG) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTROBE);
    endfunction
endpackage

// File: rtl/ictr_ctrl.sv
module ictr_ctrl
    import ictr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              gate,
    input  logic              load,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic [2:0]        mode_sel,
    output chan_cfg_t         cfg,
    output logic              restart,
    output logic              advance,
    output logic [TERM_W-1:0] start_term
);
    logic gate_q;
    logic gate_rise;

    always_comb begin
        gate_rise  = gate & ~gate_q;
        restart    = load | (gate_rise & is_retrig(cfg.mode));
        start_term = load ? expand_reload(reload_val) : cfg.term;
        advance    = tick & ~restart & (gate | ~is_gated(cfg.mode));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q   <= 1'b1;
            cfg.mode <= M_SQUARE;
            cfg.term <= TERM_W'(1) << CNT_W;
        end else begin
            gate_q <= gate;
            if (load) begin
                cfg.mode <= fold_mode(mode_sel);
                cfg.term <= expand_reload(reload_val);
            end
        end
    end
endmodule

// File: rtl/ictr_oneshot.sv
module ictr_oneshot
    import ictr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    input  logic [TERM_W-1:0] start_term,
    output logic [CNT_W-1:0]  cnt,
    output logic              reached,
    output logic              hit
);
    logic [TERM_W-1:0] rem;
    logic              past;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= TERM_W'(1) << CNT_W;
            cnt  <= '0;
            past <= 1'b0;
        end else if (restart) begin
            rem  <= start_term;
            cnt  <= CNT_W'(start_term);
            past <= 1'b0;
        end else if (advance) begin
            cnt <= cnt - CNT_W'(1);
            if (rem != '0)
                rem <= rem - TERM_W'(1);
            else
                past <= 1'b1;
        end
    end

    always_comb begin
        reached = (rem == '0);
        hit     = reached & ~past;
    end
endmodule

// File: rtl/ictr_periodic.sv
module ictr_periodic
    import ictr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    input  logic [TERM_W-1:0] term,
    output logic [TERM_W-1:0] phase,
    output logic              started
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= '0;
            started <= 1'b0;
        end else if (restart) begin
            phase   <= '0;
            started <= 1'b0;
        end else if (advance) begin
            started <= 1'b1;
            if (phase == term - TERM_W'(1))
                phase <= '0;
            else
                phase <= phase + TERM_W'(1);
        end
    end
endmodule

// File: rtl/interval_counter.sv
module interval_counter
    import ictr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             gate,
    input  logic             load,
    input  logic [15:0]      reload_val,
    input  logic [2:0]       mode_sel,
    output logic             out_line,
    output logic [15:0]      count_val
);
    chan_cfg_t         cfg;
    logic              restart;
    logic              advance;
    logic [TERM_W-1:0] start_term;
    logic [CNT_W-1:0]  os_cnt;
    logic              os_reached;
    logic              os_hit;
    logic [TERM_W-1:0] phase;
    logic              started;
    logic [2:0]        cfg_mode;

    logic [TERM_W-1:0] half;
    logic [TERM_W:0]   dbl;
    logic [TERM_W-1:0] dmod;

    ictr_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .gate       (gate),
        .load       (load),
        .reload_val (reload_val),
        .mode_sel   (mode_sel),
        .cfg        (cfg),
        .restart    (restart),
        .advance    (advance),
        .start_term (start_term)
    );

    ictr_oneshot u_oneshot (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .advance    (advance),
        .start_term (start_term),
        .cnt        (os_cnt),
        .reached    (os_reached),
        .hit        (os_hit)
    );

    ictr_periodic u_periodic (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .advance (advance),
        .term    (cfg.term),
        .phase   (phase),
        .started (started)
    );

    assign cfg_mode = cfg.mode;

    always_comb begin
        // square wave: high half is the larger one for odd terms
        half = (cfg.term + TERM_W'(1)) >> 1;
        dbl  = {phase, 1'b0};
        if (dbl >= {1'b0, cfg.term})
            dmod = TERM_W'(dbl - {1'b0, cfg.term});
        else
            dmod = TERM_W'(dbl);

        case (cfg.mode)
            M_ONESHOT, M_RETRIG: begin
                out_line  = os_reached;
                count_val = os_cnt;
            end
            M_SWSTROBE, M_HWSTROBE: begin
                out_line  = os_hit;
                count_val = os_cnt;
            end
            M_RATE: begin
                out_line  = started && (phase == '0);
                count_val = CNT_W'(cfg.term - phase);
            end
            default: begin
                out_line  = (phase < half);
                count_val = CNT_W'(cfg.term - dmod);
            end
        endcase
    end
endmodule

// File: rtl/ictr_chk.sv
module ictr_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        gate,
    input logic        load,
    input logic [15:0] reload_val,
    input logic [2:0]  cur_mode,
    input logic        out_line,
    input logic [15:0] count_val
);
    logic gate_prev;

    always_ff @(posedge clk) begin
        if (rst) gate_prev <= 1'b1;
        else     gate_prev <= gate;
    end

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (count_val == $past(reload_val)));

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load && !(gate && !gate_prev)) |=> ($stable(count_val) && $stable(out_line)));

    // R3
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 3'd0 && !gate && !load) |=> ($stable(count_val) && $stable(out_line)));

    // R3
    latch_high_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 3'd0 && out_line && !load) |=> out_line);

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 3'd4 && out_line && tick && gate && !load) |=> !out_line);
endmodule

bind interval_counter ictr_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .gate       (gate),
    .load       (load),
    .reload_val (reload_val),
    .cur_mode   (cfg_mode),
    .out_line   (out_line),
    .count_val  (count_val)
);

// File: tb/interval_counter_tb.sv
`timescale 1ns/1ps
module interval_counter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        gate = 1'b0;
    logic        load = 1'b0;
    logic [15:0] reload_val = '0;
    logic [2:0]  mode_sel = '0;
    logic        out_line;
    logic [15:0] count_val;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    interval_counter u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .gate       (gate),
        .load       (load),
        .reload_val (reload_val),
        .mode_sel   (mode_sel),
        .out_line   (out_line),
        .count_val  (count_val)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic do_load(input logic [15:0] v, input logic [2:0] m);
        reload_val = v;
        mode_sel   = m;
        load       = 1'b1;
        @(posedge clk);
        #1 load = 1'b0;
    endtask

    task automatic gate_pulse();
        gate = 1'b0;
        idle(1);
        gate = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        chk("R1 reset count", count_val, 0);
        chk("R1 reset out", out_line, 1);
        ticks(32767);
        chk("R1 high half out", out_line, 1);
        chk("R1 high half count", count_val, 2);
        ticks(1);
        chk("R1 low half out", out_line, 0);
        chk("R1 low half count", count_val, 0);
    endtask

    task automatic t_load_zero();
        do_load(16'h1234, 3'd2);
        chk("R2 load value", count_val, 16'h1234);
        do_load(16'h0000, 3'd0);
        chk("R2 zero reload count", count_val, 0);
        chk("R2 zero reload out", out_line, 0);
        ticks(1);
        chk("R2 zero reload minus one", count_val, 16'hFFFF);
        chk("R2 zero reload out low", out_line, 0);
    endtask

    task automatic t_mode0();
        do_load(16'd5, 3'd0);
        chk("R3 after load out", out_line, 0);
        ticks(4);
        chk("R3 before term out", out_line, 0);
        chk("R3 before term count", count_val, 1);
        ticks(1);
        chk("R3 at term out", out_line, 1);
        chk("R3 at term count", count_val, 0);
        ticks(2);
        chk("R3 stays high", out_line, 1);
        chk("R10 wrap count", count_val, 16'hFFFE);
        gate = 1'b0;
        do_load(16'd3, 3'd0);
        ticks(2);
        chk("R3 gate low hold count", count_val, 3);
        gate = 1'b1;
        idle(1);
        ticks(3);
        chk("R3 gate high runs out", out_line, 1);
    endtask

    task automatic t_mode0_gate_edge();
        do_load(16'd4, 3'd0);
        ticks(2);
        gate_pulse();
        chk("R9 no retrigger mode0", count_val, 2);
        ticks(1);
        chk("R9 continues mode0", count_val, 1);
    endtask

    task automatic t_mode1();
        do_load(16'd4, 3'd1);
        ticks(3);
        chk("R4 low phase out", out_line, 0);
        chk("R4 low phase count", count_val, 1);
        ticks(1);
        chk("R4 high after term", out_line, 1);
        gate_pulse();
        chk("R4 retrigger count", count_val, 4);
        chk("R4 retrigger out", out_line, 0);
    endtask

    task automatic t_mode2();
        do_load(16'd3, 3'd2);
        ticks(1);
        chk("R5 tick1 out", out_line, 0);
        chk("R5 tick1 count", count_val, 2);
        ticks(2);
        chk("R5 pulse out", out_line, 1);
        chk("R5 pulse count", count_val, 3);
        ticks(1);
        chk("R5 after pulse out", out_line, 0);
        chk("R5 after pulse count", count_val, 2);
        ticks(2);
        chk("R5 second pulse", out_line, 1);
    endtask

    task automatic t_mode3();
        int exp_out[6] = '{1, 1, 1, 0, 0, 1};
        int exp_cnt[6] = '{5, 3, 1, 4, 2, 5};
        do_load(16'd5, 3'd3);
        for (int i = 0; i < 6; i++) begin
            chk($sformatf("R6 odd out step %0d", i), out_line, exp_out[i]);
            chk($sformatf("R6 odd count step %0d", i), count_val, exp_cnt[i]);
            ticks(1);
        end
    endtask

    task automatic t_mode4();
        do_load(16'd3, 3'd4);
        ticks(2);
        chk("R7 before strobe", out_line, 0);
        ticks(1);
        chk("R7 strobe high", out_line, 1);
        ticks(1);
        chk("R7 strobe over", out_line, 0);
        ticks(10);
        chk("R7 no repeat", out_line, 0);
        chk("R10 strobe wrap count", count_val, 16'hFFF5);
        gate = 1'b0;
        ticks(3);
        chk("R7 gate low hold", count_val, 16'hFFF5);
        gate = 1'b1;
        idle(1);
    endtask

    task automatic t_mode5();
        do_load(16'd3, 3'd5);
        ticks(2);
        chk("R8 counting", count_val, 1);
        gate_pulse();
        chk("R8 retrigger count", count_val, 3);
        ticks(3);
        chk("R8 strobe high", out_line, 1);
        ticks(1);
        chk("R8 strobe over", out_line, 0);
    endtask

    task automatic t_no_tick();
        do_load(16'd10, 3'd2);
        idle(5);
        chk("R11 no tick count", count_val, 10);
        chk("R11 no tick out", out_line, 0);
    endtask

    task automatic t_folded();
        do_load(16'd3, 3'd6);
        ticks(3);
        chk("R12 code6 pulse", out_line, 1);
        chk("R12 code6 count", count_val, 3);
        do_load(16'd5, 3'd7);
        ticks(3);
        chk("R12 code7 out", out_line, 0);
        chk("R12 code7 count", count_val, 4);
    endtask

    task automatic t_mode_sample();
        do_load(16'd6, 3'd0);
        mode_sel = 3'd3;
        ticks(7);
        chk("R13 mode kept out", out_line, 1);
        chk("R13 mode kept count", count_val, 16'hFFFF);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        t_reset();
        gate = 1'b1;
        idle(1);
        t_load_zero();
        t_mode0();
        t_mode0_gate_edge();
        t_mode1();
        t_mode2();
        t_mode3();
        t_mode4();
        t_mode5();
        t_no_tick();
        t_folded();
        t_mode_sample();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule